// File: doc/BRIEF.md
# Parity-Protected Memory Error Latch

This block sits between a byte-lane data bus and a memory that stores one extra bit per byte. Every byte lane has a single nine-input parity function that serves both directions. During a write, the ninth input is forced low and the function's even-count output becomes the bit to store. The nine stored bits therefore always hold an odd number of ones. During a read, the stored parity bit drives the ninth input. An even count of ones across the nine bits marks a corrupted word.

A failed check sets a sticky error flip-flop. That flip-flop drives a non-maskable interrupt request, and only reset clears it. The memory array is not part of the block. Software cannot touch the flag.

Top module: `parity_err_guard`

## Requirements
- R1: An active-low reset `rst_n` clears `nmi_req` to 0 immediately and holds it at 0 while reset is low.
- R2: While `wr_en` is 1, `par_out[i]` is 1 when byte lane i of `wr_data` holds an even number of ones, and 0 when it holds an odd number. The nine bits written therefore carry an odd count of ones.
- R3: A read cycle is a rising clock edge with `rd_en`=1 and `wr_en`=0. If, in any lane, `rd_data` together with `rd_par[i]` holds an even number of ones, `nmi_req` reads 1 after that edge.
- R4: A cycle with `wr_en`=1 never sets `nmi_req`, even when `rd_en` is 1 and the read inputs are inconsistent.
- R5: A cycle with `rd_en`=0 never sets `nmi_req`, whatever the read inputs hold.
- R6: Once set, `nmi_req` stays 1 through later consistent reads, writes and idle cycles until reset.
- R7: Flipping any single one of the nine stored bits of a lane (data or parity) between write and read sets `nmi_req` on that read.
- R8: Flipping two of the nine stored bits of a lane leaves the parity consistent, so `nmi_req` stays 0.
- R9: Each 8-bit lane i uses `wr_data`/`rd_data` bits [8i+7:8i] with its own parity bit at index i. A failure in any lane sets the single shared flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flag samples on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Data being written |
| rd_en | input | 1 | Read strobe; the check is taken at the edge that ends the read |
| rd_data | input | DATA_W | Data returned by the memory |
| rd_par | input | DATA_W/8 | Stored parity bits returned by the memory |
| par_out | output | DATA_W/8 | Parity bits to store (valid while wr_en is 1) |
| nmi_req | output | 1 | Sticky non-maskable interrupt request |

## Verification
Writes are tried with all-zero and all-one bytes, single set bits and mixed patterns. Together these separate even-count bytes from odd-count bytes and catch a generator that inverts or drops a bit. Reads are replayed against a memory in the bench in four forms: clean, with one data bit flipped, with only the parity bit flipped, and with two bits flipped. The clean and double-flip reads must leave the flag low, and the single-flip reads must raise it. Inconsistent read data is also presented during writes and idle cycles, which shows that only a true read edge can set the flag. Good traffic after an error shows the flag stays set until reset.

// File: rtl/parity_guard_pkg.sv
package parity_guard_pkg;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned CHK_W  = LANE_W + 1;

    typedef struct packed {
        logic err;
    } guard_state_t;
endpackage

// File: rtl/par9_core.sv
module par9_core #(
    parameter int unsigned N_IN = 9
) (
    input  logic [N_IN-1:0] bits_i,
    output logic            even_hi_o,
    output logic            odd_hi_o
);
    logic [N_IN-1:0] chain;

    assign chain[0] = bits_i[0];
    for (genvar k = 1; k < N_IN; k++) begin : g_xor
        assign chain[k] = chain[k-1] ^ bits_i[k];
    end

    assign odd_hi_o  = chain[N_IN-1];
    assign even_hi_o = ~chain[N_IN-1];
endmodule

// File: rtl/lane_par.sv
module lane_par
    import parity_guard_pkg::*;
(
    input  logic              wr_en,
    input  logic [LANE_W-1:0] wr_byte,
    input  logic [LANE_W-1:0] rd_byte,
    input  logic              rd_bit,
    output logic              gen_bit,
    output logic              chk_fail
);
    logic [CHK_W-1:0] core_in;
    logic             even_hi;
    logic             odd_hi;

    always_comb begin
        if (wr_en) begin
            core_in = {1'b0, wr_byte};
        end else begin
            core_in = {rd_bit, rd_byte};
        end
    end

    par9_core #(.N_IN(CHK_W)) u_core (
        .bits_i    (core_in),
        .even_hi_o (even_hi),
        .odd_hi_o  (odd_hi)
    );

    assign gen_bit  = even_hi;
    assign chk_fail = even_hi & ~wr_en & ~odd_hi;
endmodule

// File: rtl/err_latch.sv
module err_latch
    import parity_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic fail,
    output logic flag
);
    guard_state_t st_d;
    guard_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (sample && fail) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.err;
endmodule

// File: rtl/parity_err_guard.sv
module parity_err_guard
    import parity_guard_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [LANES-1:0]  rd_par,
    output logic [LANES-1:0]  par_out,
    output logic              nmi_req
);
    logic [LANES-1:0] lane_fail;
    logic             read_edge;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_par u_lane (
            .wr_en    (wr_en),
            .wr_byte  (wr_data[i*LANE_W +: LANE_W]),
            .rd_byte  (rd_data[i*LANE_W +: LANE_W]),
            .rd_bit   (rd_par[i]),
            .gen_bit  (par_out[i]),
            .chk_fail (lane_fail[i])
        );
    end

    assign read_edge = rd_en & ~wr_en;

    err_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (read_edge),
        .fail   (|lane_fail),
        .flag   (nmi_req)
    );
endmodule

// File: rtl/parity_guard_chk.sv
module parity_guard_chk #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned LANES = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [LANES-1:0]  rd_par,
    input logic [LANES-1:0]  par_out,
    input logic              nmi_req
);
    logic any_bad;
    logic gen_ok;

    always_comb begin
        any_bad = 1'b0;
        gen_ok  = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (($countones({rd_par[i], rd_data[i*8 +: 8]}) % 2) == 0) any_bad = 1'b1;
            if (($countones({par_out[i], wr_data[i*8 +: 8]}) % 2) != 1) gen_ok = 1'b0;
        end
    end

    // R1
    a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> !nmi_req);
    // R2
    a_r2_gen_odd_total: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> gen_ok);
    // R3, R7, R9
    a_r3_bad_read_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && any_bad) |=> nmi_req);
    // R4
    a_r4_write_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !nmi_req) |=> !nmi_req);
    // R5
    a_r5_idle_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !nmi_req) |=> !nmi_req);
    // R6
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n) nmi_req |=> nmi_req);
    // R8: a consistent read never raises the flag
    a_r8_good_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !any_bad && !nmi_req) |=> !nmi_req);
endmodule

bind parity_err_guard parity_guard_chk #(.DATA_W(DATA_W)) u_guard_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .rd_par  (rd_par),
    .par_out (par_out),
    .nmi_req (nmi_req)
);

// File: tb/tb_parity_err_guard.sv
`timescale 1ns/1ps
module tb_parity_err_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data = '0;
    logic [0:0] rd_par = '0;
    logic [0:0] par_out;
    logic       nmi_req;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    logic [8:0] mem [16];
    logic       m_flag;

    parity_err_guard #(.DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rd_par(rd_par),
        .par_out(par_out), .nmi_req(nmi_req)
    );

    always #2 clk = ~clk;

    // Behavioural reference of the flag
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_flag <= 1'b0;
        else if (rd_en && !wr_en && (($countones({rd_par[0], rd_data}) % 2) == 0)) m_flag <= 1'b1;
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (nmi_req !== m_flag) begin
                errors++;
                $display("FAIL %s: nmi_req actual=%b expected=%b at %0t", cur_req, nmi_req, m_flag, $time);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(input bit w, input bit r, input logic [7:0] wd,
                        input logic [8:0] rv, input string req);
        @(posedge clk);
        #1;
        cur_req = req;
        wr_en = w; rd_en = r; wr_data = wd;
        rd_data = rv[7:0]; rd_par[0] = rv[8];
        #0.5;
        if (w) begin
            logic exp_p;
            exp_p = (($countones(wd) % 2) == 0);
            checks++;
            if (par_out[0] !== exp_p) begin
                errors++;
                $display("FAIL R2: par_out for %h actual=%b expected=%b", wd, par_out[0], exp_p);
            end
        end
    endtask

    task automatic do_write(input int a, input logic [7:0] d, input string req);
        step(1'b1, 1'b0, d, 9'h000, req);
        mem[a] = {par_out[0], d};
    endtask

    task automatic do_read(input int a, input logic [8:0] flip, input string req);
        step(1'b0, 1'b1, 8'h00, mem[a] ^ flip, req);
    endtask

    task automatic idle(input string req);
        step(1'b0, 1'b0, 8'h00, 9'h000, req);
    endtask

    task automatic pulse_reset();
        @(posedge clk);
        #1;
        cur_req = "R1";
        rst_n = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        idle("R1");

        // R2 generation across patterns
        do_write(0, 8'h00, "R2");
        do_write(1, 8'hFF, "R2");
        do_write(2, 8'h01, "R2");
        do_write(3, 8'h7F, "R2");
        do_write(4, 8'hA5, "R2");
        do_write(5, 8'h80, "R2");

        // Clean reads keep the flag low (R3 negative, R9 lane 0)
        for (int a = 0; a < 6; a++) do_read(a, 9'h000, "R3");

        // R4: write with inconsistent read inputs
        step(1'b1, 1'b1, 8'h3C, 9'h000, "R4");
        step(1'b1, 1'b1, 8'h01, 9'h0F0, "R4");
        // R5: no strobe with inconsistent read inputs
        step(1'b0, 1'b0, 8'h00, 9'h000, "R5");
        step(1'b0, 1'b0, 8'h00, 9'h003, "R5");
        idle("R5");

        // R8: double flips pass undetected
        do_read(1, 9'h003, "R8");
        do_read(4, 9'h180, "R8");
        do_read(3, 9'h041, "R8");
        idle("R8");

        // R7 / R3 / R9: single data-bit flip sets the flag
        do_read(2, 9'h010, "R7");
        idle("R3");

        // R6: stays set through good traffic
        for (int a = 0; a < 6; a++) do_read(a, 9'h000, "R6");
        do_write(6, 8'h5A, "R6");
        idle("R6");

        // R1: reset clears
        pulse_reset();
        idle("R1");
        idle("R1");

        // R7: flip only the stored parity bit
        do_read(0, 9'h100, "R7");
        idle("R6");
        pulse_reset();
        // R7: flip the top data bit
        do_read(5, 9'h080, "R7");
        idle("R6");
        pulse_reset();
        idle("R1");

        @(posedge clk);
        #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule